// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block is the attribute-memory side of a PC Card storage function. A host reaches it through a byte-wide attribute bus with separate read and write strobes. Any address below a programmable configuration base is served from a small card-information ROM held inside the block. Its contents are a parameter. At the base and above, the block decodes four byte registers at even offsets:

- an option register, which selects the addressing mode and the interrupt style and can hold the card in reset;
- a status register, which carries power-down and other host-owned flags and shows the drive's interrupt;
- a pin-replacement register, which reports a sticky ready flag;
- a socket/copy register, which reads as zero.

The block also takes the two interrupt controls of the device-control register: interrupt disable and soft reset. It combines them with the option register's reset bit and a pending-interrupt input from the drive to form the single card interrupt. Whenever the option register or the device-control register requests a reset, the block sends a one-cycle soft-reset pulse to the rest of the card. Reads are registered, so data appears one cycle after the read strobe.

Top module: `pccard_cfg_regs`

## Requirements
- R1: After reset the option register reads 0x00, the status register reads 0x00 and the pin register reads 0x0C. The outputs card_irq, soft_rst, mode_sel, irq_level and mrdy_ovr are all 0.
- R2: A write at offset 0 stores the data ANDed with 0xCF. mode_sel carries bits 5:0 of the option register, with 0 = memory-mapped, 1 = contiguous I/O, 2 = primary I/O and 3 = secondary I/O. irq_level carries bit 6.
- R3: An option write with bit 7 set produces a one-cycle soft_rst pulse and clears the status register, the ready flag and mrdy_ovr. The option register keeps the masked written value. While bit 7 stays set, card_irq is held low.
- R4: A write at offset 2 stores only the bits under 0x74 (bits 6, 5, 4 and 2). On read, bit 7 is 0 and bit 1 shows the pending interrupt.
- R5: A status write that changes bit 2 (power-down) sets the ready flag, which is bit 5 of the pin register. A status write that leaves bit 2 unchanged does not set it.
- R6: While the device-control interrupt-disable input is set, status-register reads return bit 1 as 0.
- R7: A pin-register read returns the ready flag in bit 5 ORed with 0x0C. A pin write keeps the ready flag and loads data bit 1 into mrdy_ovr.
- R8: Offset 6 reads zero and ignores writes. Odd offsets and offsets of 8 or more read zero and ignore writes.
- R9: A read below cfg_base returns ROM byte N at address N when N < ROM_DEPTH, where byte N is bits 8N+7:8N of ROM_IMAGE. Addresses at or beyond ROM_DEPTH return 0.
- R10: card_irq is 1 exactly when the pending input was 1 at the previous clock edge, interrupt disable is 0, the device-control soft reset is 0 and option bit 7 is 0.
- R11: A ctl_wr with ctl_srst set latches both control bits, produces a one-cycle soft_rst pulse, clears status, ready and mrdy_ovr, and holds card_irq low until a later ctl_wr clears it.
- R12: attr_rdata updates on the clock edge that samples attr_rd and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Attribute address of the option register |
| attr_addr | input | AW | Attribute byte address |
| attr_rd | input | 1 | Read strobe |
| attr_wr | input | 1 | Write strobe |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Registered read data |
| ctl_wr | input | 1 | Device-control write strobe |
| ctl_nien | input | 1 | Device-control interrupt-disable bit |
| ctl_srst | input | 1 | Device-control soft-reset bit |
| drv_irq_pend | input | 1 | Pending interrupt from the drive |
| card_irq | output | 1 | Card interrupt, active high |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the card |
| mode_sel | output | 6 | Addressing mode field of the option register |
| irq_level | output | 1 | Level-mode interrupt select |
| mrdy_ovr | output | 1 | Stored pin-register bit 1 |

## Verification
All state changes are registered on the edge that samples a strobe. A register write is therefore visible to a read issued in the next cycle, and read data is due one edge after attr_rd. soft_rst is high for exactly the cycle after the causing write. card_irq follows the pending input with one cycle of delay, while a change to the control bits gates it in the cycle after ctl_wr. The bench drives every input on the falling edge and samples on the falling edge after the edge that is due to produce the result. It also checks the cycle after each soft_rst pulse to confirm that the pulse has dropped.

// File: rtl/pccard_cfg_pkg.sv
package pccard_cfg_pkg;

    // Register offsets from the configuration base; the even spacing is
    // what the host software decodes.
    typedef enum logic [2:0] {
        REG_OPT  = 3'd0,
        REG_STAT = 3'd2,
        REG_PIN  = 3'd4,
        REG_SOCK = 3'd6
    } cfg_reg_e;

    localparam logic [7:0] OPT_WMASK  = 8'hCF;
    localparam logic [7:0] STAT_WMASK = 8'h74;
    localparam logic [7:0] PIN_FIXED  = 8'h0C;

    localparam int OPT_RESET_BIT = 7;
    localparam int OPT_LEVEL_BIT = 6;
    localparam int STAT_PD_BIT   = 2;
    localparam int STAT_INT_BIT  = 1;
    localparam int PIN_READY_BIT = 5;
    localparam int PIN_MRDY_BIT  = 1;

    typedef struct packed {
        logic [7:0] opt;
        logic [7:0] stat;
        logic       ready;
        logic       mrdy;
        logic       nien;
        logic       srst;
    } cfg_state_t;

    function automatic logic [7:0] status_view(input logic [7:0] stored,
                                               input logic pend,
                                               input logic nien);
        logic [7:0] v;
        v = stored & STAT_WMASK;
        v[STAT_INT_BIT] = pend & ~nien;
        return v;
    endfunction

    function automatic logic [7:0] pin_view(input logic ready);
        logic [7:0] v;
        v = PIN_FIXED;
        v[PIN_READY_BIT] = ready;
        return v;
    endfunction

endpackage

// File: rtl/pccard_cis_rom.sv
module pccard_cis_rom #(
    parameter int AW = 12,
    parameter int DEPTH = 16,
    parameter logic [8*DEPTH-1:0] IMAGE = '0
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] bytes [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        assign bytes[g] = IMAGE[8*g +: 8];
    end

    always_comb begin
        data = 8'h00;
        if (addr < AW'(DEPTH))
            data = bytes[addr[IW-1:0]];
    end
endmodule

// File: rtl/pccard_irq_gate.sv
module pccard_irq_gate (
    input  logic pend_q,
    input  logic ctl_nien_q,
    input  logic ctl_srst_q,
    input  logic opt_reset_q,
    output logic irq
);
    logic blocked;

    always_comb begin
        blocked = ctl_nien_q | ctl_srst_q | opt_reset_q;
        irq     = pend_q & ~blocked;
    end
endmodule

// File: rtl/pccard_cfg_regs.sv
module pccard_cfg_regs
    import pccard_cfg_pkg::*;
#(
    parameter int AW = 12,
    parameter int ROM_DEPTH = 16,
    parameter logic [8*ROM_DEPTH-1:0] ROM_IMAGE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] attr_addr,
    input  logic          attr_rd,
    input  logic          attr_wr,
    input  logic [7:0]    attr_wdata,
    output logic [7:0]    attr_rdata,
    input  logic          ctl_wr,
    input  logic          ctl_nien,
    input  logic          ctl_srst,
    input  logic          drv_irq_pend,
    output logic          card_irq,
    output logic          soft_rst,
    output logic [5:0]    mode_sel,
    output logic          irq_level,
    output logic          mrdy_ovr
);
    cfg_state_t    st;
    logic          pend_q;
    logic          in_cfg;
    logic [AW-1:0] off;
    logic          sel_opt, sel_stat, sel_pin;
    logic [7:0]    rom_data;
    logic [7:0]    rd_mux;
    logic          opt_wr, stat_wr, pin_wr;

    always_comb begin
        in_cfg   = attr_addr >= cfg_base;
        off      = attr_addr - cfg_base;
        sel_opt  = in_cfg && (off == AW'(REG_OPT));
        sel_stat = in_cfg && (off == AW'(REG_STAT));
        sel_pin  = in_cfg && (off == AW'(REG_PIN));
        opt_wr   = attr_wr && sel_opt;
        stat_wr  = attr_wr && sel_stat;
        pin_wr   = attr_wr && sel_pin;
    end

    pccard_cis_rom #(.AW(AW), .DEPTH(ROM_DEPTH), .IMAGE(ROM_IMAGE)) u_rom (
        .addr (attr_addr),
        .data (rom_data)
    );

    always_comb begin
        rd_mux = 8'h00;
        if (!in_cfg)
            rd_mux = rom_data;
        else if (sel_opt)
            rd_mux = st.opt;
        else if (sel_stat)
            rd_mux = status_view(st.stat, pend_q, st.nien);
        else if (sel_pin)
            rd_mux = pin_view(st.ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '0;
            pend_q     <= 1'b0;
            soft_rst   <= 1'b0;
            attr_rdata <= 8'h00;
        end else begin
            pend_q   <= drv_irq_pend;
            soft_rst <= 1'b0;
            if (attr_rd)
                attr_rdata <= rd_mux;

            if (opt_wr) begin
                st.opt <= attr_wdata & OPT_WMASK;
            end else if (stat_wr) begin
                if (st.stat[STAT_PD_BIT] != attr_wdata[STAT_PD_BIT])
                    st.ready <= 1'b1;
                st.stat <= attr_wdata & STAT_WMASK;
            end else if (pin_wr) begin
                st.mrdy <= attr_wdata[PIN_MRDY_BIT];
            end

            if (ctl_wr) begin
                st.nien <= ctl_nien;
                st.srst <= ctl_srst;
            end

            if ((opt_wr && attr_wdata[OPT_RESET_BIT]) || (ctl_wr && ctl_srst)) begin
                soft_rst <= 1'b1;
                st.stat  <= 8'h00;
                st.ready <= 1'b0;
                st.mrdy  <= 1'b0;
            end
        end
    end

    pccard_irq_gate u_irq (
        .pend_q      (pend_q),
        .ctl_nien_q  (st.nien),
        .ctl_srst_q  (st.srst),
        .opt_reset_q (st.opt[OPT_RESET_BIT]),
        .irq         (card_irq)
    );

    assign mode_sel  = st.opt[5:0];
    assign irq_level = st.opt[OPT_LEVEL_BIT];
    assign mrdy_ovr  = st.mrdy;
endmodule

// File: rtl/pccard_cfg_checker.sv
module pccard_cfg_checker #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] attr_addr,
    input logic          attr_rd,
    input logic          attr_wr,
    input logic [7:0]    attr_wdata,
    input logic [7:0]    attr_rdata,
    input logic          ctl_wr,
    input logic          ctl_srst,
    input logic          drv_irq_pend,
    input logic          card_irq,
    input logic          soft_rst,
    input logic [7:0]    opt_q,
    input logic          nien_q,
    input logic          srst_q
);
    // R2: option write stores masked data
    p_opt_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (attr_wr && attr_addr == cfg_base) |=> (opt_q == ($past(attr_wdata) & 8'hCF)));

    // R3 / R11: reset pulse lasts one cycle
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);

    // R11: pulse only follows a write
    p_pulse_cause_r11: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> $past(attr_wr || (ctl_wr && ctl_srst)));

    // R10: interrupt only when all gates open
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        card_irq |-> (!opt_q[7] && !nien_q && !srst_q));

    // R10: interrupt follows the pending input one cycle late
    p_irq_pend_r10: assert property (@(posedge clk) disable iff (rst)
        card_irq |-> $past(drv_irq_pend));

    // R12: read data holds without a read
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !attr_rd |=> $stable(attr_rdata));
endmodule

bind pccard_cfg_regs pccard_cfg_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_base     (cfg_base),
    .attr_addr    (attr_addr),
    .attr_rd      (attr_rd),
    .attr_wr      (attr_wr),
    .attr_wdata   (attr_wdata),
    .attr_rdata   (attr_rdata),
    .ctl_wr       (ctl_wr),
    .ctl_srst     (ctl_srst),
    .drv_irq_pend (drv_irq_pend),
    .card_irq     (card_irq),
    .soft_rst     (soft_rst),
    .opt_q        (st.opt),
    .nien_q       (st.nien),
    .srst_q       (st.srst)
);

// File: tb/test_pccard_cfg_regs.sv
module test_pccard_cfg_regs;
    localparam int AW = 12;
    localparam int DEPTH = 16;
    // byte i of the image is (i+1)*15
    localparam logic [8*DEPTH-1:0] IMG = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
    localparam logic [AW-1:0] BASE = 12'h200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] attr_addr = '0;
    logic          attr_rd = 1'b0, attr_wr = 1'b0;
    logic [7:0]    attr_wdata = 8'h00;
    logic [7:0]    attr_rdata;
    logic          ctl_wr = 1'b0, ctl_nien = 1'b0, ctl_srst = 1'b0;
    logic          drv_irq_pend = 1'b0;
    logic          card_irq, soft_rst, irq_level, mrdy_ovr;
    logic [5:0]    mode_sel;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pccard_cfg_regs #(.AW(AW), .ROM_DEPTH(DEPTH), .ROM_IMAGE(IMG)) i_pccard_cfg_regs (
        .clk(clk), .rst(rst), .cfg_base(BASE), .attr_addr(attr_addr),
        .attr_rd(attr_rd), .attr_wr(attr_wr), .attr_wdata(attr_wdata),
        .attr_rdata(attr_rdata), .ctl_wr(ctl_wr), .ctl_nien(ctl_nien),
        .ctl_srst(ctl_srst), .drv_irq_pend(drv_irq_pend), .card_irq(card_irq),
        .soft_rst(soft_rst), .mode_sel(mode_sel), .irq_level(irq_level),
        .mrdy_ovr(mrdy_ovr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        attr_addr = a; attr_rd = 1'b1;
        @(negedge clk);
        attr_rd = 1'b0;
        d = attr_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        @(negedge clk);
        attr_addr = a; attr_wdata = v; attr_wr = 1'b1;
        @(negedge clk);
        attr_wr = 1'b0;
    endtask

    task automatic ctl(input logic nien, input logic srst);
        @(negedge clk);
        ctl_nien = nien; ctl_srst = srst; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", {7'b0, card_irq}, 8'h00);
        check("R1 soft_rst", {7'b0, soft_rst}, 8'h00);
        check("R1 mode", {irq_level, mrdy_ovr, mode_sel}, 8'h00);
        rd(BASE, d);      check("R1 option", d, 8'h00);
        rd(BASE + 2, d);  check("R1 status", d, 8'h00);
        rd(BASE + 4, d);  check("R1 pin", d, 8'h0C);
    endtask

    task automatic t_option();
        logic [7:0] d;
        for (int m = 0; m < 4; m++) begin
            wr(BASE, 8'(m));
            check("R2 mode_sel", {2'b0, mode_sel}, 8'(m));
        end
        wr(BASE, 8'h7F);
        rd(BASE, d);  check("R2 masked option", d, 8'h4F);
        check("R2 level", {7'b0, irq_level}, 8'h01);
        check("R2 mode masked", {2'b0, mode_sel}, 8'h0F);
        wr(BASE, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        wr(BASE + 2, 8'hFF);
        rd(BASE + 2, d);  check("R4 status mask", d, 8'h74);
        rd(BASE + 4, d);  check("R5 ready on pd change", d, 8'h2C);
        ctl(1'b0, 1'b1);  // clear through soft reset
        ctl(1'b0, 1'b0);
        wr(BASE + 2, 8'h70);
        rd(BASE + 2, d);  check("R4 status store", d, 8'h70);
        rd(BASE + 4, d);  check("R5 no ready without pd change", d, 8'h0C);
        wr(BASE + 2, 8'h04);
        rd(BASE + 4, d);  check("R5 ready after pd set", d, 8'h2C);
    endtask

    task automatic t_pins();
        logic [7:0] d;
        wr(BASE + 4, 8'hFF);
        check("R7 mrdy set", {7'b0, mrdy_ovr}, 8'h01);
        rd(BASE + 4, d);  check("R7 ready kept", d, 8'h2C);
        wr(BASE + 4, 8'h00);
        check("R7 mrdy clear", {7'b0, mrdy_ovr}, 8'h00);
        rd(BASE + 4, d);  check("R7 ready still kept", d, 8'h2C);
    endtask

    task automatic t_unused();
        logic [7:0] d;
        wr(BASE + 6, 8'hFF);
        rd(BASE + 6, d);  check("R8 socket reads zero", d, 8'h00);
        wr(BASE + 1, 8'hFF);
        wr(BASE + 3, 8'h00);
        wr(BASE + 8, 8'hFF);
        rd(BASE + 1, d);  check("R8 odd offset", d, 8'h00);
        rd(BASE + 9, d);  check("R8 far offset", d, 8'h00);
        rd(BASE, d);      check("R8 option untouched", d, 8'h00);
        rd(BASE + 2, d);  check("R8 status untouched", d, 8'h04);
        rd(BASE + 4, d);  check("R8 pin untouched", d, 8'h2C);
    endtask

    task automatic t_rom();
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i += 5) begin
            rd(AW'(i), d);  check("R9 rom byte", d, 8'((i + 1) * 15));
        end
        rd(AW'(DEPTH), d);  check("R9 beyond rom", d, 8'h00);
        rd(BASE - 1, d);    check("R9 just below base", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(BASE + 2, 8'h00);
        @(negedge clk); drv_irq_pend = 1'b1;
        @(negedge clk);
        check("R10 irq one cycle after pend", {7'b0, card_irq}, 8'h01);
        rd(BASE + 2, d);  check("R4 status shows pend", d, 8'h02);
        ctl(1'b1, 1'b0);
        check("R10 irq masked by nien", {7'b0, card_irq}, 8'h00);
        rd(BASE + 2, d);  check("R6 status hides pend", d, 8'h00);
        ctl(1'b0, 1'b0);
        check("R10 irq back", {7'b0, card_irq}, 8'h01);
        @(negedge clk); drv_irq_pend = 1'b0;
        @(negedge clk);
        check("R10 irq drops with pend", {7'b0, card_irq}, 8'h00);
        drv_irq_pend = 1'b1;
    endtask

    task automatic t_ctrl_srst();
        logic [7:0] d;
        wr(BASE + 2, 8'h10);
        wr(BASE + 4, 8'h02);
        ctl(1'b0, 1'b1);
        check("R11 pulse", {7'b0, soft_rst}, 8'h01);
        check("R11 irq held", {7'b0, card_irq}, 8'h00);
        check("R11 mrdy cleared", {7'b0, mrdy_ovr}, 8'h00);
        @(negedge clk);
        check("R11 pulse one cycle", {7'b0, soft_rst}, 8'h00);
        rd(BASE + 2, d);  check("R11 status cleared", d, 8'h02);
        rd(BASE + 4, d);  check("R11 ready cleared", d, 8'h0C);
        check("R11 irq still held", {7'b0, card_irq}, 8'h00);
        ctl(1'b0, 1'b0);
        check("R11 irq released", {7'b0, card_irq}, 8'h01);
    endtask

    task automatic t_opt_srst();
        logic [7:0] d;
        wr(BASE + 2, 8'h20);
        wr(BASE, 8'hB1);
        check("R3 pulse", {7'b0, soft_rst}, 8'h01);
        check("R3 irq held", {7'b0, card_irq}, 8'h00);
        @(negedge clk);
        check("R3 pulse one cycle", {7'b0, soft_rst}, 8'h00);
        rd(BASE, d);      check("R3 option kept", d, 8'h81);
        rd(BASE + 2, d);  check("R3 status cleared", d, 8'h02);
        check("R3 irq still held", {7'b0, card_irq}, 8'h00);
        wr(BASE, 8'h00);
        check("R3 irq released", {7'b0, card_irq}, 8'h01);
        check("R3 no pulse without bit7", {7'b0, soft_rst}, 8'h00);
        @(negedge clk); drv_irq_pend = 1'b0;
    endtask

    task automatic t_read_hold();
        logic [7:0] d;
        wr(BASE, 8'h03);
        rd(BASE, d);  check("R12 read data", d, 8'h03);
        wr(BASE, 8'h01);
        @(negedge clk);
        check("R12 data holds", attr_rdata, 8'h03);
        rd(BASE, d);  check("R12 new read", d, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_option();
        t_status();
        t_pins();
        t_unused();
        t_rom();
        t_irq();
        t_ctrl_srst();
        t_opt_srst();
        t_read_hold();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule